// File: doc/BRIEF.md
# Ones-Complement Adder-Subtractor with End-Around Carry

This block adds or subtracts two W-bit signed integers held in ones-complement form. The result appears in the same cycle, because the block has no registers. The sign bits go through the adder like any other bit. When the addition carries out of the top position, that carry is folded back into the bottom position. This is the end-around carry, and it yields a correct ones-complement result.

Subtraction negates the second operand by inverting every bit, because in this encoding that inversion is negation. No carry-in is injected. Both zero encodings are legal, all zeros and all ones (negative zero), on the inputs and on the result. An overflow flag shows when the true result lies outside the range the width can hold, which is plus or minus (2^(W-1) - 1).

Top module: `oc_addsub`

## Requirements
- R1: With `sub_i` = 0, whenever `ovf_o` is 0, the signed value of `sum_o` equals the signed value of `a_i` plus the signed value of `b_i`. A word with its top bit at 1 means minus the value of its bitwise inverse.
- R2: With `sub_i` = 1, `b_i` is inverted bitwise and then added, with no carry-in. Whenever `ovf_o` is 0, the value of `sum_o` equals a minus b.
- R3: A carry out of bit W-1 is added into bit 0. At W=5, 01100 + 11110 gives 01011, and 11010 + 11011 gives 10110.
- R4: With no carry out of the top bit, the raw sum is passed on unchanged. At W=5, 11010 + 00100 gives 11110.
- R5: Folding the carry back in never produces a second carry out. For every operand pair, `sum_o` equals the raw sum, reduced by 2^W and increased by 1 when the raw sum is 2^W or more.
- R6: `ovf_o` is 1 exactly when the two words entering the adder have equal sign bits and the sign bit of `sum_o` differs from them. This is the same as the true result lying outside the range plus or minus (2^(W-1) - 1).
- R7: Negative zero is handled as zero. 0 + all-ones gives all-ones. x + all-ones gives x for any nonzero x. x - x gives all-ones.
- R8: The width W is a parameter with a default of 8, and every port that carries data is W bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand, ones-complement |
| b_i | input | W | Second operand, ones-complement |
| sub_i | input | 1 | 0 adds, 1 subtracts b from a |
| sum_o | output | W | Ones-complement result after end-around carry |
| ovf_o | output | 1 | Result out of representable range |

## Verification
The bench builds two copies of the block. One uses W=5, so that every operand pair in both modes (2048 vectors) can be swept exhaustively. That sweep reaches every carry pattern, both zero encodings and every overflow boundary. The other copy uses the default W=8. It confirms the default width and takes seeded random vectors, plus directed cases at the edges of the positive and negative ranges.

// File: rtl/oc_addsub.sv
module oc_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  localparam longint LIM = (longint'(1) <<< (W - 1)) - 1;

  logic [W-1:0] opb;
  logic [W:0]   wide;
  logic [W-1:0] raw;
  logic         cy;

  assign opb   = sub_i ? ~b_i : b_i;
  assign wide  = {1'b0, a_i} + {1'b0, opb};
  assign raw   = wide[W-1:0];
  assign cy    = wide[W];
  assign sum_o = raw + {{(W-1){1'b0}}, cy};
  assign ovf_o = (a_i[W-1] == opb[W-1]) && (sum_o[W-1] != a_i[W-1]);

  function automatic longint val(input logic [W-1:0] x);
    logic [W-1:0] nx;
    nx = ~x;
    return x[W-1] ? -longint'(nx) : longint'(x);
  endfunction

  longint truth;
  always_comb begin
    truth = val(a_i) + (sub_i ? -val(b_i) : val(b_i));
    AST_NO_SECOND_CARRY: assert (!(cy && (&raw))); // R5
    AST_VALUE_MATCH: assert (ovf_o || (val(sum_o) == truth)); // R1 R2
    AST_OVF_RANGE: assert (ovf_o == ((truth > LIM) || (truth < -LIM))); // R6
    AST_NEGZERO_IDENT: assert (sub_i || !(&b_i) || !(|a_i) || (sum_o == a_i)); // R7
    AST_SELF_SUB_NEGZERO: assert (!sub_i || (a_i != b_i) || (&sum_o)); // R7
  end
endmodule

// File: tb/oc_addsub_tb.sv
module oc_addsub_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [4:0] a5, b5, s5;
  logic       m5, o5;
  logic [7:0] a8, b8, s8;
  logic       m8, o8;

  oc_addsub #(.W(5)) dut5_i (.a_i(a5), .b_i(b5), .sub_i(m5), .sum_o(s5), .ovf_o(o5));
  oc_addsub          dut_i  (.a_i(a8), .b_i(b8), .sub_i(m8), .sum_o(s8), .ovf_o(o8));

  function automatic longint ref_sum(int w, longint a, longint b, bit sub);
    longint mask, bb, s;
    mask = (longint'(1) <<< w) - 1;
    bb = sub ? (~b & mask) : b;
    s = a + bb;
    if (s > mask) s = s - mask;
    return s;
  endfunction

  function automatic longint dec(int w, longint x);
    longint mask;
    mask = (longint'(1) <<< w) - 1;
    return ((x >>> (w - 1)) & 1) != 0 ? -(mask - x) : x;
  endfunction

  function automatic bit ref_ovf(int w, longint a, longint b, bit sub);
    longint v, lim;
    lim = (longint'(1) <<< (w - 1)) - 1;
    v = dec(w, a) + (sub ? -dec(w, b) : dec(w, b));
    return (v > lim) || (v < -lim);
  endfunction

  task automatic chk(string tag, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run5(string tag, logic [4:0] a, logic [4:0] b, logic m);
    longint es;
    bit eo;
    @(posedge clk);
    a5 = a; b5 = b; m5 = m;
    @(negedge clk);
    es = ref_sum(5, longint'(a), longint'(b), m);
    eo = ref_ovf(5, longint'(a), longint'(b), m);
    chk({tag, " sum"}, longint'(s5) == es, longint'(s5), es);
    chk({tag, " ovf"}, o5 == eo, longint'(o5), longint'(eo));
  endtask

  task automatic run8(string tag, logic [7:0] a, logic [7:0] b, logic m);
    longint es;
    bit eo;
    @(posedge clk);
    a8 = a; b8 = b; m8 = m;
    @(negedge clk);
    es = ref_sum(8, longint'(a), longint'(b), m);
    eo = ref_ovf(8, longint'(a), longint'(b), m);
    chk({tag, " sum"}, longint'(s8) == es, longint'(s8), es);
    chk({tag, " ovf"}, o8 == eo, longint'(o8), longint'(eo));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h1C0DE;
    void'($urandom(seed));
    a5 = '0; b5 = '0; m5 = 1'b0;
    a8 = '0; b8 = '0; m8 = 1'b0;
    @(negedge clk);
    chk("R8 width", ($bits(s8) == 8) && ($bits(a8) == 8), longint'($bits(s8)), 8);
    chk("R7 idle zero", (s8 == 8'h00) && !o8, longint'(s8), 0);

    run5("R3 12-1", 5'b01100, 5'b11110, 1'b0);
    chk("R3 12-1 literal", s5 == 5'b01011, longint'(s5), 11);
    run5("R3 -5-4", 5'b11010, 5'b11011, 1'b0);
    chk("R3 -5-4 literal", s5 == 5'b10110, longint'(s5), 22);
    run5("R4 -5+4", 5'b11010, 5'b00100, 1'b0);
    chk("R4 -5+4 literal", s5 == 5'b11110, longint'(s5), 30);
    run5("R7 0+negzero", 5'b00000, 5'b11111, 1'b0);
    chk("R7 0+negzero literal", s5 == 5'b11111, longint'(s5), 31);
    run5("R7 x-x", 5'b01101, 5'b01101, 1'b1);
    chk("R7 x-x literal", s5 == 5'b11111, longint'(s5), 31);
    run5("R2 sub 12-1", 5'b01100, 5'b00001, 1'b1);
    chk("R2 sub literal", s5 == 5'b01011, longint'(s5), 11);
    run5("R6 15+1", 5'b01111, 5'b00001, 1'b0);
    chk("R6 15+1 flag", o5 == 1'b1, longint'(o5), 1);
    run5("R6 -15-1", 5'b10000, 5'b00001, 1'b1);
    chk("R6 -15-1 flag", o5 == 1'b1, longint'(o5), 1);

    // R1 R2 R5 R6 exhaustive sweep at W=5
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++)
          run5(m ? "R2 R5 R6 sweep" : "R1 R5 R6 sweep", 5'(a), 5'(b), 1'(m));

    run8("R8 127+1", 8'h7F, 8'h01, 1'b0);
    chk("R6 127+1 flag", o8 == 1'b1, longint'(o8), 1);
    run8("R8 127+negzero", 8'h7F, 8'hFF, 1'b0);
    chk("R7 w8 ident", s8 == 8'h7F, longint'(s8), 127);
    run8("R8 -127-0", 8'h80, 8'h00, 1'b1);
    for (int i = 0; i < 3000; i++)
      run8("R1 R2 R8 random", 8'($urandom), 8'($urandom), 1'($urandom));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule